// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that pulls a system reset when software stops servicing it. A clock-enable chain divides the core clock twice: first by an 8-bit programmable prescaler, then by a power-of-two post-divider between 16 and 128. Each divided tick steps a 16-bit down-counter. When the counter runs past zero while the timer and its reset output are both enabled, the block drives a registered reset pulse that is one clock wide.

Software works through a small write/read register bus with three words: a control word, a reload word and the live count. Software services the watchdog ("kicks" it) by writing the count word. On expiry the counter refills from the reload word. Software can change the reload word only while the timer is stopped.

Top module: `wdog_top`

## Requirements
- R1: After reset the control word reads 0x0000_8039: prescaler 0x80, timer on, divider select 3, reset output on. The reload word and the count word both read 0x0000_8000.
- R2: The word offsets are 0x0 for control, 0x4 for reload and 0x8 for count. The control fields are prescaler [15:8], timer enable bit 5, divider select [4:3] and reset enable bit 0. All other control bits and any unmapped offset read as zero.
- R3: One divided tick lasts (prescaler+1) * 2^(4+select) clock cycles. The first tick lands that many edges after the edge that sets the timer enable.
- R4: With count N loaded while the timer is stopped, the reset pulse appears on edge (N+1) * tick period after the enabling edge. The count word reads the live counter value at all times.
- R5: The reset pulse comes from a register, lasts exactly one clock cycle, and does not repeat until a later expiry.
- R6: On expiry the counter refills from the reload word.
- R7: A write to the count word loads the written value on that edge and wins over a simultaneous tick or expiry. It does not disturb the phase of the divided clock.
- R8: An expiry produces a pulse only when both the timer enable and the reset enable are set. With reset enable clear, the counter still refills silently.
- R9: A write to the reload word is ignored while the timer enable is set.
- R10: While the timer enable is clear, the counter holds its value and no ticks occur. Both dividers restart from zero when the timer is enabled again.
- R11: Loading count 1 and then enabling the timer forces a reset pulse after two divided ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdog_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
The bench measures, to the exact edge, when the pulse arrives for several prescaler, select and count combinations. A divider that is off by one, or a counter that fires at N instead of N+1 ticks, shows up as a shifted edge count. Targeted cases exercise the following:
- a kick issued partway through a period, which a design that reset the prescaler phase or ignored the kick would time wrongly;
- an expiry with the reset output disabled, which a faulty design would turn into a pulse or fail to refill;
- a reload write while running, which a faulty design would accept;
- a stop/restart sequence, where a frozen counter that drifts, or a divider that keeps its old phase, would give the wrong restart timing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ADDR_W       = 4;
  localparam int unsigned PRE_W        = 8;
  localparam int unsigned SEL_W        = 2;
  localparam int unsigned CNT_W        = 16;
  localparam int unsigned DIV_LOG2_MIN = 4;
  // post-divider counter must reach 2^(DIV_LOG2_MIN + max select) - 1
  localparam int unsigned DIV_W        = DIV_LOG2_MIN + (1 << SEL_W) - 1;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFF_RELOAD = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFF_COUNT  = ADDR_W'(4'h8);

  localparam int unsigned POS_PRE = 8;
  localparam int unsigned POS_EN  = 5;
  localparam int unsigned POS_SEL = 3;
  localparam int unsigned POS_RST = 0;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             rst_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{pre: 8'h80, en: 1'b1, sel: 2'd3, rst_en: 1'b1};
  localparam logic [CNT_W-1:0] CNT_RESET = CNT_W'(16'h8000);

  function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[POS_PRE +: PRE_W] = c.pre;
    w[POS_EN]           = c.en;
    w[POS_SEL +: SEL_W] = c.sel;
    w[POS_RST]          = c.rst_en;
    return w;
  endfunction

  function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.pre    = w[POS_PRE +: PRE_W];
    c.en     = w[POS_EN];
    c.sel    = w[POS_SEL +: SEL_W];
    c.rst_en = w[POS_RST];
    return c;
  endfunction

  // last value of the post-divider for a given select: 2^(4+sel) - 1
  function automatic logic [DIV_W-1:0] div_last(input logic [SEL_W-1:0] sel);
    logic [DIV_W:0] span;
    span = (DIV_W+1)'(1) << (DIV_LOG2_MIN + int'(sel));
    return DIV_W'(span - 1'b1);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [CW-1:0] live_cnt,
  output ctrl_t         ctrl_q,
  output logic [CW-1:0] reload_q,
  output logic          cnt_wr,
  output logic [CW-1:0] cnt_wdata,
  output logic [DW-1:0] bus_rdata
);
  logic hit_ctrl, hit_reload, hit_count, reload_wr;

  assign hit_ctrl   = bus_wr && (bus_addr == AW'(OFF_CTRL));
  assign hit_reload = bus_wr && (bus_addr == AW'(OFF_RELOAD));
  assign hit_count  = bus_wr && (bus_addr == AW'(OFF_COUNT));
  // reload word is locked while the timer runs
  assign reload_wr  = hit_reload && !ctrl_q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      reload_q <= CNT_RESET;
    end else begin
      if (hit_ctrl)  ctrl_q   <= word_to_ctrl(DATA_W'(bus_wdata));
      if (reload_wr) reload_q <= bus_wdata[CW-1:0];
    end
  end

  assign cnt_wr    = hit_count;
  assign cnt_wdata = bus_wdata[CW-1:0];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFF_CTRL))        bus_rdata = DW'(ctrl_to_word(ctrl_q));
    else if (bus_addr == AW'(OFF_RELOAD)) bus_rdata = DW'(reload_q);
    else if (bus_addr == AW'(OFF_COUNT))  bus_rdata = DW'(live_cnt);
  end
endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen
  import wdog_pkg::*;
#(
  parameter int unsigned PW  = PRE_W,
  parameter int unsigned SW  = SEL_W,
  parameter int unsigned DVW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] pre,
  input  logic [SW-1:0] sel,
  output logic          pre_tick,
  output logic          tick
);
  logic [PW-1:0]  pcnt_q;
  logic [DVW-1:0] dcnt_q;
  logic           div_hit;

  assign pre_tick = en && (pcnt_q == pre);
  assign div_hit  = (dcnt_q == DVW'(div_last(SEL_W'(sel))));
  assign tick     = pre_tick && div_hit;

  // both stages sit at zero while stopped, so an enable restarts them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (!en) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else begin
      pcnt_q <= pre_tick ? '0 : pcnt_q + 1'b1;
      if (pre_tick) dcnt_q <= div_hit ? '0 : dcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned   CW        = CNT_W,
  parameter logic [CW-1:0] RESET_VAL = CNT_RESET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rst_en,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt_q,
  output logic          expire,
  output logic          rst_pulse_q
);
  assign expire = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= RESET_VAL;
      rst_pulse_q <= 1'b0;
    end else begin
      rst_pulse_q <= expire && rst_en && !ld;
      if (ld)          cnt_q <= ld_val;
      else if (expire) cnt_q <= reload;
      else if (tick)   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wdog_rst_o
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q, cnt_q, cnt_wdata;
  logic              cnt_wr, pre_tick, tick, expire;
  logic              ctrl_en, ctrl_rst_en;

  assign ctrl_en     = ctrl_q.en;
  assign ctrl_rst_en = ctrl_q.rst_en;

  wdog_regs #(.AW(AW), .DW(DW), .CW(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .live_cnt(cnt_q), .ctrl_q(ctrl_q),
    .reload_q(reload_q), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .bus_rdata(bus_rdata)
  );

  wdog_tick_gen #(.PW(PRE_W), .SW(SEL_W), .DVW(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .pre(ctrl_q.pre),
    .sel(ctrl_q.sel), .pre_tick(pre_tick), .tick(tick)
  );

  wdog_counter #(.CW(CNT_W), .RESET_VAL(CNT_RESET)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rst_en(ctrl_rst_en),
    .ld(cnt_wr), .ld_val(cnt_wdata), .reload(reload_q), .cnt_q(cnt_q),
    .expire(expire), .rst_pulse_q(wdog_rst_o)
  );

  logic unused_pre_tick;
  assign unused_pre_tick = pre_tick;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wdog_rst_o,
  input logic          ctrl_en,
  input logic          ctrl_rst_en,
  input logic          tick,
  input logic          expire,
  input logic          cnt_wr,
  input logic [CW-1:0] cnt_wdata,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] reload_q
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |=> !wdog_rst_o); // R5
  AST_PULSE_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> $past(expire)); // R4
  AST_PULSE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> ($past(ctrl_en) && $past(ctrl_rst_en))); // R8
  AST_EXPIRY_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(expire) && !$past(cnt_wr)) |-> (cnt_q == $past(reload_q))); // R6
  AST_KICK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_wr) |-> (cnt_q == $past(cnt_wdata))); // R7
  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_en) |-> $stable(reload_q)); // R9
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctrl_en) && !$past(cnt_wr)) |-> $stable(cnt_q)); // R10
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ctrl_en); // R10
endmodule

bind wdog_top wdog_checker #(.CW(16)) u_wdog_chk (
  .clk(clk), .rst_n(rst_n), .wdog_rst_o(wdog_rst_o), .ctrl_en(ctrl_en),
  .ctrl_rst_en(ctrl_rst_en), .tick(tick), .expire(expire), .cnt_wr(cnt_wr),
  .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .reload_q(reload_q)
);

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdog_rst_o;

  always #5 clk = ~clk;

  wdog_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_rst_o(wdog_rst_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // vector: pre[31:24] sel[23:16] count[15:0]
  localparam logic [31:0] VEC [8] = '{
    32'h0000_0000, 32'h0000_0003, 32'h0100_0002, 32'h0001_0004,
    32'h0003_0001, 32'h0302_0005, 32'hFF00_0000, 32'h0002_0009
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  function automatic logic [31:0] cw(int pre, int sel, bit en, bit rst);
    return (32'(pre) << 8) | (32'(en) << 5) | (32'(sel) << 3) | 32'(rst);
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_pulse(int limit, output int k);
    k = 0;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk); @(negedge clk);
      k++;
      if (wdog_rst_o) return;
    end
    k = -1;
  endtask

  task automatic idle_no_pulse(int n, string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdog_rst_o) seen = 1;
    end
    check(req, 32'(seen), 32'd0);
  endtask

  task automatic prep(int pre, int sel, int n, bit rst);
    wr(4'h0, cw(pre, sel, 0, rst));
    wr(4'h4, 32'(n));
    wr(4'h8, 32'(n));
  endtask

  initial begin
    logic [31:0] d;
    int k;
    int exp;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 layout of reset word
    rd(4'h0, d); check("R1 ctrl reset", d, 32'h0000_8039);
    rd(4'h4, d); check("R1 reload reset", d, 32'h0000_8000);
    rd(4'h8, d); check("R1 count reset", d, 32'h0000_8000);
    rd(4'hC, d); check("R2 unmapped reads zero", d, 32'h0);

    // R9 reload locked while running (timer on from reset)
    wr(4'h4, 32'h1234);
    rd(4'h4, d); check("R9 reload ignored while enabled", d, 32'h0000_8000);

    // R2 field positions and unused bits
    wr(4'h0, 32'hFFFF_FFDF);
    rd(4'h0, d); check("R2 ctrl field mask", d, 32'h0000_FF19);

    // table of timing vectors: R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      int pre, sel, n;
      pre = int'(VEC[v][31:24]); sel = int'(VEC[v][23:16]); n = int'(VEC[v][15:0]);
      exp = (pre + 1) * (16 << sel) * (n + 1);
      prep(pre, sel, n, 1);
      wr(4'h0, cw(pre, sel, 1, 1));
      wait_pulse(exp + 50, k);
      check("R3 R4 pulse edge", 32'(k), 32'(exp));
      @(negedge clk);
      check("R5 pulse one cycle", 32'(wdog_rst_o), 32'd0);
      rd(4'h8, d); check("R6 refill after expiry", d, 32'(n));
    end

    // R8 expiry without reset enable: silent refill
    wr(4'h0, cw(0, 0, 0, 0));
    wr(4'h4, 32'd5);
    wr(4'h8, 32'd0);
    wr(4'h0, cw(0, 0, 1, 0));
    idle_no_pulse(40, "R8 no pulse with reset disabled");
    rd(4'h8, d); check("R8 R6 silent refill then count", d, 32'd4);

    // R7 kick midway
    prep(0, 0, 3, 1);
    wr(4'h0, cw(0, 0, 1, 1));
    idle_no_pulse(40, "R7 no early pulse");
    rd(4'h8, d); check("R4 live count", d, 32'd1);
    wr(4'h8, 32'd3);
    rd(4'h8, d); check("R7 kick loads", d, 32'd3);
    wait_pulse(200, k);
    check("R7 pulse after kick", 32'(k), 32'(16 * 6 - 42));

    // R11 forced reset
    wr(4'h0, cw(0, 0, 0, 1));
    wr(4'h8, 32'd1);
    wr(4'h0, cw(0, 0, 1, 1));
    wait_pulse(100, k);
    check("R11 forced reset", 32'(k), 32'd32);

    // R10 freeze while stopped, dividers restart on enable
    prep(0, 0, 2, 1);
    wr(4'h0, cw(0, 0, 1, 1));
    repeat (20) begin @(posedge clk); @(negedge clk); end
    wr(4'h0, cw(0, 0, 0, 1));
    idle_no_pulse(50, "R10 no pulse while stopped");
    rd(4'h8, d); check("R10 count frozen", d, 32'd1);
    wr(4'h0, cw(0, 0, 1, 1));
    wait_pulse(100, k);
    check("R10 dividers restart", 32'(k), 32'd32);

    finish_run();
  end
endmodule